// File: doc/BRIEF.md
# Vector Element Category Write Merger

This block builds the write-back data for one element group of a vector destination register. Each cycle it may accept a group that carries the freshly computed result elements, the previous contents of the destination elements, the index of the group's first element, the start index and the length of the operation, and one mask bit per element. Every element is placed in exactly one of four categories: prestart, active, inactive or tail. The merged data and a write enable per element are then produced from that category.

Active elements always take the new result and prestart elements always keep their previous value. Inactive and tail elements each follow their own policy bit, which picks between keeping the previous value and writing zero. The two policy bits live in a small register: after reset, inactive elements are kept and tail elements are zeroed. A "kept" element is presented with its old data. By default its write enable is raised, so that a design with register renaming copies the value into the new physical register. With the parameter `UNDIST_WE` set to 0 the write enable is dropped instead, which suits a design without renaming.

Both the input and the output side are valid/ready streams, with a single register stage between them. A group is taken on a clock edge where `grp_valid` and `grp_ready` are both high. The result appears on the output one cycle later and stays there, unchanged, until a clock edge where `mrg_valid` and `mrg_ready` are both high. `grp_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer stalls the producer without losing any group.

Top module: `vec_elem_merge`

## Requirements
- R1: Lane i (i = 0 to LANES-1) has index `grp_base + i`. It is prestart if its index is below `grp_start`. Otherwise it is tail if its index is at least `grp_len`. Otherwise it is active if its mask bit `grp_mask[i]` is 1, and inactive if that bit is 0. Prestart takes precedence over tail.
- R2: An active lane outputs its `grp_new` element with its write enable at 1.
- R3: An inactive lane outputs zero with write enable 1 when the inactive policy bit is 1. It outputs its `grp_old` element with write enable UNDIST_WE (default 1) when that bit is 0.
- R4: A tail lane outputs zero with write enable 1 when the tail policy bit is 1. It outputs its `grp_old` element with write enable UNDIST_WE when that bit is 0.
- R5: A prestart lane always outputs its `grp_old` element with write enable UNDIST_WE, whatever the policy bits are.
- R6: When `grp_unmasked` is 1, every lane that would otherwise be inactive is active instead, regardless of the mask bits.
- R7: When `grp_start >= grp_len`, no lane of the group is active.
- R8: After reset the inactive policy bit is 0 and the tail policy bit is 1. A cycle with `pol_wr` high loads both bits from `pol_inact_zero` and `pol_tail_zero`. A group accepted on that same edge still uses the previous bits.
- R9: `mrg_cat` bits [2i+1:2i] give lane i's category: 0 prestart, 1 active, 2 inactive, 3 tail.
- R10: A group accepted on an edge is on the output from the next cycle. The output holds valid and stable while `mrg_ready` is low. `grp_ready` equals `!mrg_valid || mrg_ready`.
- R11: During and after reset `mrg_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pol_wr | input | 1 | Load the policy register |
| pol_inact_zero | input | 1 | New inactive policy bit (1 = zero) |
| pol_tail_zero | input | 1 | New tail policy bit (1 = zero) |
| grp_valid | input | 1 | Input group valid |
| grp_ready | output | 1 | Input group accepted when high with valid |
| grp_base | input | IDX_W | Index of lane 0 |
| grp_start | input | IDX_W | First element index to process |
| grp_len | input | IDX_W | Element count of the operation |
| grp_mask | input | LANES | Per-lane mask bits |
| grp_unmasked | input | 1 | Ignore mask, treat in-range lanes as active |
| grp_new | input | LANES*ELEM_W | New result elements, lane 0 in low bits |
| grp_old | input | LANES*ELEM_W | Previous destination elements |
| mrg_valid | output | 1 | Merged group valid |
| mrg_ready | input | 1 | Consumer ready |
| mrg_data | output | LANES*ELEM_W | Merged write data |
| mrg_we | output | LANES | Per-lane write enables |
| mrg_cat | output | 2*LANES | Per-lane category codes |

## Verification
Almost any fault in this block shows up at the ports one cycle after the faulty group is accepted. A wrong category decision shows up as a wrong `mrg_cat` code, and usually also as a lane carrying new data where old or zero data was due. A corrupted policy register turns kept lanes into zero lanes, or the other way round, on the very next group that has an inactive or tail lane. A fault in the output register shows up either as a group that is lost or duplicated, or as data that changes while `mrg_ready` is low. The bench finds it at the next transfer, because it checks every transfer against a queue-based model.

// File: rtl/vem_pkg.sv
package vem_pkg;

  typedef enum logic [1:0] {
    CAT_PRE  = 2'd0,
    CAT_ACT  = 2'd1,
    CAT_INA  = 2'd2,
    CAT_TAIL = 2'd3
  } vem_cat_e;

  typedef struct packed {
    logic inact_zero;
    logic tail_zero;
  } vem_pol_t;

  localparam vem_pol_t POL_RESET = '{inact_zero: 1'b0, tail_zero: 1'b1};

endpackage

// File: rtl/vem_policy_reg.sv
module vem_policy_reg
  import vem_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr,
  input  logic     inact_zero,
  input  logic     tail_zero,
  output vem_pol_t pol
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol <= POL_RESET;
    end else if (wr) begin
      pol.inact_zero <= inact_zero;
      pol.tail_zero  <= tail_zero;
    end
  end

  // R8: a write is visible on the following cycle
  a_r8_pol_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (pol.inact_zero == $past(inact_zero)) && (pol.tail_zero == $past(tail_zero)));

  // R8: without a write the policy does not move
  a_r8_pol_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(pol));

endmodule

// File: rtl/vem_classify.sv
module vem_classify
  import vem_pkg::*;
#(
  parameter int LANES = 4,
  parameter int IDX_W = 8
) (
  input  logic [IDX_W-1:0]   base,
  input  logic [IDX_W-1:0]   start,
  input  logic [IDX_W-1:0]   len,
  input  logic [LANES-1:0]   mask,
  input  logic               unmasked,
  output logic [2*LANES-1:0] cat
);

  localparam int XW = IDX_W + 1;

  logic [XW-1:0] start_x;
  logic [XW-1:0] len_x;

  assign start_x = {1'b0, start};
  assign len_x   = {1'b0, len};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [XW-1:0] idx;
    vem_cat_e      c;

    assign idx = {1'b0, base} + XW'(i);

    always_comb begin
      if (idx < start_x)             c = CAT_PRE;
      else if (idx >= len_x)         c = CAT_TAIL;
      else if (unmasked || mask[i])  c = CAT_ACT;
      else                           c = CAT_INA;
    end

    assign cat[2*i +: 2] = c;

    // R7: an empty range never yields an active lane
    always_comb begin
      if (start_x >= len_x) a_r7_no_active: assert (c != CAT_ACT);
    end
  end

endmodule

// File: rtl/vem_lane_merge.sv
module vem_lane_merge
  import vem_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int ELEM_W    = 16,
  parameter bit UNDIST_WE = 1'b1
) (
  input  logic [2*LANES-1:0]      cat,
  input  vem_pol_t                pol,
  input  logic [LANES*ELEM_W-1:0] new_d,
  input  logic [LANES*ELEM_W-1:0] old_d,
  output logic [LANES*ELEM_W-1:0] data,
  output logic [LANES-1:0]        we
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [ELEM_W-1:0] nv;
    logic [ELEM_W-1:0] ov;
    logic [ELEM_W-1:0] dv;
    logic              wv;

    assign nv = new_d[i*ELEM_W +: ELEM_W];
    assign ov = old_d[i*ELEM_W +: ELEM_W];

    always_comb begin
      dv = ov;
      wv = UNDIST_WE;
      case (vem_cat_e'(cat[2*i +: 2]))
        CAT_PRE: begin
          dv = ov;
          wv = UNDIST_WE;
        end
        CAT_ACT: begin
          dv = nv;
          wv = 1'b1;
        end
        CAT_INA: begin
          if (pol.inact_zero) begin
            dv = '0;
            wv = 1'b1;
          end
        end
        CAT_TAIL: begin
          if (pol.tail_zero) begin
            dv = '0;
            wv = 1'b1;
          end
        end
        default: begin
          dv = ov;
          wv = UNDIST_WE;
        end
      endcase
    end

    assign data[i*ELEM_W +: ELEM_W] = dv;
    assign we[i] = wv;
  end

endmodule

// File: rtl/vem_out_stage.sv
module vem_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_pl,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_pl
);

  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) out_pl <= in_pl;
  end

  // R10: a stalled output holds its valid and payload
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pl));

  // R10: an accepted group is presented on the next cycle
  a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && (out_pl == $past(in_pl)));

  // R10: when nothing is accepted and the output drains, it empties
  a_r10_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

endmodule

// File: rtl/vec_elem_merge.sv
module vec_elem_merge
  import vem_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int ELEM_W    = 16,
  parameter int IDX_W     = 8,
  parameter bit UNDIST_WE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pol_wr,
  input  logic                    pol_inact_zero,
  input  logic                    pol_tail_zero,
  input  logic                    grp_valid,
  output logic                    grp_ready,
  input  logic [IDX_W-1:0]        grp_base,
  input  logic [IDX_W-1:0]        grp_start,
  input  logic [IDX_W-1:0]        grp_len,
  input  logic [LANES-1:0]        grp_mask,
  input  logic                    grp_unmasked,
  input  logic [LANES*ELEM_W-1:0] grp_new,
  input  logic [LANES*ELEM_W-1:0] grp_old,
  output logic                    mrg_valid,
  input  logic                    mrg_ready,
  output logic [LANES*ELEM_W-1:0] mrg_data,
  output logic [LANES-1:0]        mrg_we,
  output logic [2*LANES-1:0]      mrg_cat
);

  localparam int DW = LANES * ELEM_W;
  localparam int PW = DW + LANES + 2 * LANES;

  vem_pol_t           pol;
  logic [2*LANES-1:0] cat_c;
  logic [DW-1:0]      data_c;
  logic [LANES-1:0]   we_c;
  logic [PW-1:0]      pl_in;
  logic [PW-1:0]      pl_out;

  vem_policy_reg u_pol (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (pol_wr),
    .inact_zero (pol_inact_zero),
    .tail_zero  (pol_tail_zero),
    .pol        (pol)
  );

  vem_classify #(.LANES(LANES), .IDX_W(IDX_W)) u_cls (
    .base     (grp_base),
    .start    (grp_start),
    .len      (grp_len),
    .mask     (grp_mask),
    .unmasked (grp_unmasked),
    .cat      (cat_c)
  );

  vem_lane_merge #(.LANES(LANES), .ELEM_W(ELEM_W), .UNDIST_WE(UNDIST_WE)) u_mrg (
    .cat   (cat_c),
    .pol   (pol),
    .new_d (grp_new),
    .old_d (grp_old),
    .data  (data_c),
    .we    (we_c)
  );

  assign pl_in = {cat_c, we_c, data_c};

  vem_out_stage #(.W(PW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (grp_valid),
    .in_ready  (grp_ready),
    .in_pl     (pl_in),
    .out_valid (mrg_valid),
    .out_ready (mrg_ready),
    .out_pl    (pl_out)
  );

  assign mrg_data = pl_out[DW-1:0];
  assign mrg_we   = pl_out[DW +: LANES];
  assign mrg_cat  = pl_out[DW+LANES +: 2*LANES];

  logic accept;
  assign accept = grp_valid && grp_ready;

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    // R2: an active lane carries the new element with write enable
    a_r2_active_new: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (cat_c[2*i +: 2] == CAT_ACT) |=>
        (mrg_data[i*ELEM_W +: ELEM_W] == $past(grp_new[i*ELEM_W +: ELEM_W])) && mrg_we[i]);

    // R5: a prestart lane carries the old element
    a_r5_pre_old: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (cat_c[2*i +: 2] == CAT_PRE) |=>
        (mrg_data[i*ELEM_W +: ELEM_W] == $past(grp_old[i*ELEM_W +: ELEM_W])) && (mrg_we[i] == UNDIST_WE));

    // R4: a tail lane under the zeroing policy is written with zero
    a_r4_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (cat_c[2*i +: 2] == CAT_TAIL) && pol.tail_zero |=>
        (mrg_data[i*ELEM_W +: ELEM_W] == '0) && mrg_we[i]);

    // R3: an inactive lane under the keep policy carries the old element
    a_r3_inact_keep: assert property (@(posedge clk) disable iff (!rst_n)
      accept && (cat_c[2*i +: 2] == CAT_INA) && !pol.inact_zero |=>
        (mrg_data[i*ELEM_W +: ELEM_W] == $past(grp_old[i*ELEM_W +: ELEM_W])));
  end

  // R11: nothing is presented right after reset
  a_r11_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !mrg_valid);

endmodule

// File: tb/vec_elem_merge_tb_top.sv
module vec_elem_merge_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 4;
  localparam int ELEM_W = 16;
  localparam int IDX_W  = 8;
  localparam int DW     = LANES * ELEM_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pol_wr = 1'b0, pol_inact_zero = 1'b0, pol_tail_zero = 1'b0;
  logic grp_valid = 1'b0, grp_ready;
  logic [IDX_W-1:0] grp_base = '0, grp_start = '0, grp_len = '0;
  logic [LANES-1:0] grp_mask = '0;
  logic grp_unmasked = 1'b0;
  logic [DW-1:0] grp_new = '0, grp_old = '0;
  logic mrg_valid, mrg_ready = 1'b0;
  logic [DW-1:0] mrg_data;
  logic [LANES-1:0] mrg_we;
  logic [2*LANES-1:0] mrg_cat;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_elem_merge #(.LANES(LANES), .ELEM_W(ELEM_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .pol_wr(pol_wr), .pol_inact_zero(pol_inact_zero), .pol_tail_zero(pol_tail_zero),
    .grp_valid(grp_valid), .grp_ready(grp_ready),
    .grp_base(grp_base), .grp_start(grp_start), .grp_len(grp_len),
    .grp_mask(grp_mask), .grp_unmasked(grp_unmasked),
    .grp_new(grp_new), .grp_old(grp_old),
    .mrg_valid(mrg_valid), .mrg_ready(mrg_ready),
    .mrg_data(mrg_data), .mrg_we(mrg_we), .mrg_cat(mrg_cat)
  );

  int tests = 0;
  int fails = 0;

  logic [DW-1:0]      q_data[$];
  logic [LANES-1:0]   q_we[$];
  logic [2*LANES-1:0] q_cat[$];
  string              q_tag[$];

  bit m_inz = 1'b0;
  bit m_tz  = 1'b1;

  function automatic string cat_req(int c);
    case (c)
      0: return "R5";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  // Behavioural expectation for the group currently on the inputs
  task automatic push_expected(string tag);
    logic [DW-1:0] d;
    logic [LANES-1:0] w;
    logic [2*LANES-1:0] c;
    for (int i = 0; i < LANES; i++) begin
      int idx = int'(grp_base) + i;
      int k;
      logic [ELEM_W-1:0] nv = grp_new[i*ELEM_W +: ELEM_W];
      logic [ELEM_W-1:0] ov = grp_old[i*ELEM_W +: ELEM_W];
      if (idx < int'(grp_start)) k = 0;
      else if (idx >= int'(grp_len)) k = 3;
      else if (grp_unmasked || grp_mask[i]) k = 1;
      else k = 2;
      c[2*i +: 2] = 2'(k);
      if (k == 1) begin
        d[i*ELEM_W +: ELEM_W] = nv; w[i] = 1'b1;
      end else if ((k == 2 && m_inz) || (k == 3 && m_tz)) begin
        d[i*ELEM_W +: ELEM_W] = '0; w[i] = 1'b1;
      end else begin
        d[i*ELEM_W +: ELEM_W] = ov; w[i] = 1'b1;
      end
    end
    q_data.push_back(d); q_we.push_back(w); q_cat.push_back(c); q_tag.push_back(tag);
  endtask

  // Evaluate the coming clock edge after inputs were driven at the falling edge
  task automatic evaluate(string tag);
    #1;
    tests++;
    if (mrg_valid !== (q_data.size() > 0)) begin
      fails++;
      $display("FAIL R10/R11 %s: mrg_valid %0b expected %0b", tag, mrg_valid, q_data.size() > 0);
    end
    tests++;
    if (grp_ready !== (!mrg_valid || mrg_ready)) begin
      fails++;
      $display("FAIL R10 %s: grp_ready %0b expected %0b", tag, grp_ready, !mrg_valid || mrg_ready);
    end
    if (mrg_valid && mrg_ready && q_data.size() > 0) begin
      logic [DW-1:0] ed = q_data.pop_front();
      logic [LANES-1:0] ew = q_we.pop_front();
      logic [2*LANES-1:0] ec = q_cat.pop_front();
      string et = q_tag.pop_front();
      for (int i = 0; i < LANES; i++) begin
        int k = int'(ec[2*i +: 2]);
        tests++;
        if (mrg_cat[2*i +: 2] !== ec[2*i +: 2]) begin
          fails++;
          $display("FAIL R1/R9 %s lane %0d: cat %0d expected %0d", et, i, mrg_cat[2*i +: 2], k);
        end
        tests++;
        if (mrg_data[i*ELEM_W +: ELEM_W] !== ed[i*ELEM_W +: ELEM_W] || mrg_we[i] !== ew[i]) begin
          fails++;
          $display("FAIL %s %s lane %0d: data %h we %0b expected data %h we %0b", cat_req(k), et, i,
                   mrg_data[i*ELEM_W +: ELEM_W], mrg_we[i], ed[i*ELEM_W +: ELEM_W], ew[i]);
        end
      end
    end
    if (grp_valid && grp_ready) push_expected(tag);
    if (pol_wr) begin
      m_inz = pol_inact_zero;
      m_tz  = pol_tail_zero;
    end
  endtask

  task automatic send(string tag, int base, int start, int len, logic [LANES-1:0] mask, bit unm);
    @(negedge clk);
    pol_wr = 1'b0; grp_valid = 1'b1; mrg_ready = 1'b1;
    grp_base = IDX_W'(base); grp_start = IDX_W'(start); grp_len = IDX_W'(len);
    grp_mask = mask; grp_unmasked = unm;
    grp_new = {$urandom, $urandom}; grp_old = {$urandom, $urandom};
    evaluate(tag);
  endtask

  task automatic set_pol(bit inz, bit tz, bit with_group);
    @(negedge clk);
    pol_wr = 1'b1; pol_inact_zero = inz; pol_tail_zero = tz;
    grp_valid = with_group; mrg_ready = 1'b1;
    grp_base = 8'd0; grp_start = 8'd0; grp_len = 8'd2; grp_mask = 4'b0001; grp_unmasked = 1'b0;
    grp_new = {$urandom, $urandom}; grp_old = {$urandom, $urandom};
    evaluate("R8 same-edge");
  endtask

  task automatic idle(string tag, bit rdy);
    @(negedge clk);
    pol_wr = 1'b0; grp_valid = 1'b0; mrg_ready = rdy;
    evaluate(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: output idle while in reset
    tests++;
    if (mrg_valid !== 1'b0) begin
      fails++;
      $display("FAIL R11: mrg_valid %0b expected 0", mrg_valid);
    end
    rst_n = 1'b1;

    // R1 R8: reset policy, all four categories in one group
    send("R1 R8 default", 0, 1, 3, 4'b0101, 1'b0);
    // R1: nonzero base shifts the categories
    send("R1 base", 8, 9, 11, 4'b1010, 1'b0);
    // R6: unmasked makes every in-range lane active
    send("R6 unmasked", 4, 4, 8, 4'b0000, 1'b0);
    send("R6 unmasked", 4, 5, 7, 4'b0000, 1'b1);
    // R7: empty range
    send("R7 empty", 0, 3, 2, 4'b1111, 1'b1);
    send("R7 equal", 0, 2, 2, 4'b1111, 1'b1);
    // R8: write accompanied by a group uses old policy, later groups new
    set_pol(1'b1, 1'b0, 1'b1);
    send("R3 R4 swapped pol", 0, 1, 3, 4'b0101, 1'b0);
    set_pol(1'b1, 1'b1, 1'b0);
    send("R3 R4 both zero", 0, 0, 2, 4'b0010, 1'b0);
    set_pol(1'b0, 1'b0, 1'b0);
    send("R3 R4 both keep", 2, 0, 4, 4'b0001, 1'b0);
    // R5: prestart ignores policy
    send("R5 all pre", 0, 10, 20, 4'b1111, 1'b1);
    set_pol(1'b0, 1'b1, 1'b0);

    // R10: stall with back-pressure
    @(negedge clk);
    grp_valid = 1'b1; mrg_ready = 1'b0; grp_base = 8'd0; grp_start = 8'd0; grp_len = 8'd3;
    grp_mask = 4'b0110; grp_unmasked = 1'b0; grp_new = {$urandom, $urandom}; grp_old = {$urandom, $urandom};
    evaluate("R10 stall");
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      grp_new = {$urandom, $urandom};
      evaluate("R10 stall");
    end
    idle("R10 drain", 1'b1);
    idle("R10 drain", 1'b1);

    // Mixed traffic
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      pol_wr = ($urandom_range(0, 15) == 0);
      pol_inact_zero = $urandom_range(0, 1);
      pol_tail_zero = $urandom_range(0, 1);
      grp_valid = ($urandom_range(0, 3) != 0);
      mrg_ready = ($urandom_range(0, 3) != 0);
      grp_base = IDX_W'($urandom_range(0, 20));
      grp_start = IDX_W'($urandom_range(0, 24));
      grp_len = IDX_W'($urandom_range(0, 24));
      grp_mask = LANES'($urandom);
      grp_unmasked = ($urandom_range(0, 4) == 0);
      grp_new = {$urandom, $urandom};
      grp_old = {$urandom, $urandom};
      evaluate("R1 R6 R7 R10 mixed");
    end
    for (int n = 0; n < 4; n++) idle("R10 final drain", 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule